// File: doc/BRIEF.md
# Nibble-Serial Register Access Slave

This block sits on the device side of a byte-wide host link and turns a stream of small command bytes into accesses to a bank of 8-bit registers. Every command byte carries a 4-bit opcode in its upper half and a 4-bit payload in its lower half. Two commands assemble an 8-bit register address, and two more assemble an 8-bit data value. The command that supplies the upper data nibble also commits the write.

A read command returns the byte at the current address on a separate transmit stream with a valid/ready handshake. A variant of the read command steps the address forward afterwards, so a host can stream consecutive registers without resending the address. Six addresses form a read-only window onto two 24-bit capture positions supplied by neighbouring logic. Writes that succeed are announced on a one-cycle strobe so that the logic around the block can act on its registers.

Top module: `nibreg_slave`

## Requirements
- R1: After reset every storage register reads 0x00, the current address is 0x00, the saved low data nibble is 0x0, `rsp_valid` and `reg_we` are low and `cmd_ready` is high.
- R2: Opcode 0x0 (bits 7:4) loads the low nibble of the current address from bits 3:0, and opcode 0x1 loads the high nibble. Each leaves the other nibble of the address unchanged.
- R3: Opcode 0x2 saves bits 3:0 as the low data nibble. Opcode 0x3 writes {bits 3:0, saved low nibble} to the current address. In the next cycle `reg_we` is high for exactly one cycle, with `reg_waddr` and `reg_wdata` showing the address and the byte that were written.
- R4: Writes never move the address, and the saved low data nibble survives a commit. Several data pairs, or a lone opcode 0x3, may follow one address, and each one overwrites that same register.
- R5: Opcode 0x4 places the byte at the current address on `rsp_data` with `rsp_valid` high in the cycle after the command is accepted. The address is left unchanged.
- R6: Opcode 0x5 returns the byte at the current address in the same way and then adds one to the address, wrapping from 0xFF to 0x00.
- R7: While `rsp_valid` is high, `cmd_ready` is low. `rsp_data` holds steady until the cycle in which `rsp_ready` is also high.
- R8: Opcodes 0x6 to 0xF are accepted and then dropped. They leave the address and the saved data nibble unchanged, raise no write strobe and produce no reply.
- R9: Addresses POS_BASE to POS_BASE+5 (default 0xF0) read the live `trig_pos` bytes and then the live `stop_pos` bytes, lowest byte first in each. Writes to these addresses are dropped and raise no `reg_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_data | input | 8 | Command byte: opcode in 7:4, payload nibble in 3:0 |
| cmd_valid | input | 1 | Command byte present |
| cmd_ready | output | 1 | Slave can take a command byte |
| rsp_data | output | 8 | Read reply byte |
| rsp_valid | output | 1 | Reply byte present |
| rsp_ready | input | 1 | Host takes the reply byte |
| trig_pos | input | 24 | Trigger capture position, read through the window |
| stop_pos | input | 24 | Stop capture position, read through the window |
| reg_we | output | 1 | One-cycle strobe for a committed write |
| reg_waddr | output | 8 | Address of the committed write |
| reg_wdata | output | 8 | Byte of the committed write |

## Verification
On every cycle the assertions check the following: the input stalls while a reply is pending, and a stalled reply stays put. Every accepted read produces a reply on the next cycle. A write strobe comes only from an accepted commit opcode, carries that opcode's nibble, and never points into the position window. Unused opcodes cause neither a strobe nor a reply. Some behaviour needs the bench's scenarios, which compare replies against a model of the register bank: that nibbles are kept between commands, that bursts go to one address, that the address wraps after an incrementing read, and that the window bytes come back in their fixed order.

// File: rtl/nibreg_pkg.sv
package nibreg_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;
    localparam int ADDR_W = 2 * NIB_W;
    localparam int POS_W  = 24;
    localparam int POS_BYTES = POS_W / BYTE_W;
    localparam int WIN_LEN   = 2 * POS_BYTES;

    localparam logic [NIB_W-1:0] OP_ADDR_LO  = 4'h0;
    localparam logic [NIB_W-1:0] OP_ADDR_HI  = 4'h1;
    localparam logic [NIB_W-1:0] OP_DATA_LO  = 4'h2;
    localparam logic [NIB_W-1:0] OP_DATA_WR  = 4'h3;
    localparam logic [NIB_W-1:0] OP_READ     = 4'h4;
    localparam logic [NIB_W-1:0] OP_READ_INC = 4'h5;

    typedef struct packed {
        logic             set_alo;
        logic             set_ahi;
        logic             set_dlo;
        logic             commit;
        logic             read;
        logic             bump;
        logic [NIB_W-1:0] nib;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b, input logic fire);
        cmd_t c;
        c     = '0;
        c.nib = b[NIB_W-1:0];
        if (fire) begin
            case (b[BYTE_W-1:NIB_W])
                OP_ADDR_LO:  c.set_alo = 1'b1;
                OP_ADDR_HI:  c.set_ahi = 1'b1;
                OP_DATA_LO:  c.set_dlo = 1'b1;
                OP_DATA_WR:  c.commit  = 1'b1;
                OP_READ:     c.read    = 1'b1;
                OP_READ_INC: begin
                    c.read = 1'b1;
                    c.bump = 1'b1;
                end
                default: ;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/nibreg_decode.sv
module nibreg_decode
    import nibreg_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic              fire,
    output cmd_t              cmd
);
    always_comb cmd = decode_cmd(cmd_byte, fire);
endmodule

// File: rtl/nibreg_assemble.sv
module nibreg_assemble
    import nibreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              wr_req
);
    logic [NIB_W-1:0] data_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            data_lo  <= '0;
        end else begin
            if (cmd.set_alo) cur_addr[NIB_W-1:0]      <= cmd.nib;
            if (cmd.set_ahi) cur_addr[ADDR_W-1:NIB_W] <= cmd.nib;
            if (cmd.set_dlo) data_lo                  <= cmd.nib;
            if (cmd.bump)    cur_addr                 <= cur_addr + 1'b1;
        end
    end

    assign wr_byte = {cmd.nib, data_lo};
    assign wr_req  = cmd.commit;
endmodule

// File: rtl/nibreg_bank.sv
module nibreg_bank
    import nibreg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] POS_BASE = 8'hF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [POS_W-1:0]  trig_pos,
    input  logic [POS_W-1:0]  stop_pos,
    output logic [BYTE_W-1:0] rdata,
    output logic              wr_ok
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] win_bytes [WIN_LEN];
    logic [ADDR_W-1:0] win_off;
    logic              in_win;

    for (genvar g = 0; g < POS_BYTES; g++) begin : g_win
        assign win_bytes[g]             = trig_pos[g*BYTE_W +: BYTE_W];
        assign win_bytes[g + POS_BYTES] = stop_pos[g*BYTE_W +: BYTE_W];
    end

    assign win_off = addr - POS_BASE;
    assign in_win  = (win_off < ADDR_W'(WIN_LEN));
    assign wr_ok   = wr_req && !in_win;

    always_comb begin
        rdata = mem[addr];
        if (in_win) begin
            for (int i = 0; i < WIN_LEN; i++) begin
                if (win_off == ADDR_W'(i)) rdata = win_bytes[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_ok) begin
            mem[addr] <= wdata;
        end
    end
endmodule

// File: rtl/nibreg_txq.sv
module nibreg_txq
    import nibreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    input  logic              rsp_ready,
    output logic              rsp_valid,
    output logic [BYTE_W-1:0] rsp_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else if (load) begin
            rsp_valid <= 1'b1;
            rsp_data  <= din;
        end else if (rsp_valid && rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/nibreg_slave.sv
module nibreg_slave
    import nibreg_pkg::*;
#(
    parameter logic [7:0] POS_BASE = 8'hF0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  cmd_data,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    output logic [7:0]  rsp_data,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    input  logic [23:0] trig_pos,
    input  logic [23:0] stop_pos,
    output logic        reg_we,
    output logic [7:0]  reg_waddr,
    output logic [7:0]  reg_wdata
);
    cmd_t              cmd;
    logic              fire;
    logic [ADDR_W-1:0] cur_addr;
    logic [BYTE_W-1:0] wr_byte;
    logic [BYTE_W-1:0] rd_byte;
    logic              wr_req;
    logic              wr_ok;

    assign cmd_ready = !rsp_valid;
    assign fire      = cmd_valid && cmd_ready;

    nibreg_decode u_dec (
        .cmd_byte (cmd_data),
        .fire     (fire),
        .cmd      (cmd)
    );

    nibreg_assemble u_asm (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .cur_addr (cur_addr),
        .wr_byte  (wr_byte),
        .wr_req   (wr_req)
    );

    nibreg_bank #(.POS_BASE(POS_BASE)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_req   (wr_req),
        .addr     (cur_addr),
        .wdata    (wr_byte),
        .trig_pos (trig_pos),
        .stop_pos (stop_pos),
        .rdata    (rd_byte),
        .wr_ok    (wr_ok)
    );

    nibreg_txq u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (cmd.read),
        .din       (rd_byte),
        .rsp_ready (rsp_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_we    <= 1'b0;
            reg_waddr <= '0;
            reg_wdata <= '0;
        end else begin
            reg_we <= wr_ok;
            if (wr_ok) begin
                reg_waddr <= cur_addr;
                reg_wdata <= wr_byte;
            end
        end
    end
endmodule

// File: rtl/nibreg_slave_chk.sv
module nibreg_slave_chk #(
    parameter logic [7:0] POS_BASE = 8'hF0
) (
    input logic       clk,
    input logic       rst,
    input logic [7:0] cmd_data,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [7:0] rsp_data,
    input logic       rsp_valid,
    input logic       rsp_ready,
    input logic       reg_we,
    input logic [7:0] reg_waddr,
    input logic [7:0] reg_wdata
);
    logic       acc;
    logic [7:0] woff;
    assign acc  = cmd_valid && cmd_ready;
    assign woff = reg_waddr - POS_BASE;

    a_r7_stall_input: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !cmd_ready);

    a_r7_hold_reply: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    a_r5_reply_follows_read: assert property (@(posedge clk) disable iff (rst)
        (acc && (cmd_data[7:4] == 4'h4 || cmd_data[7:4] == 4'h5)) |=> rsp_valid);

    a_r3_strobe_from_commit: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> $past(acc && cmd_data[7:4] == 4'h3));

    a_r3_strobe_high_nibble: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> (reg_wdata[7:4] == $past(cmd_data[3:0])));

    a_r8_unused_opcode_silent: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_data[7:4] > 4'h5) |=> (!rsp_valid && !reg_we));

    a_r9_window_no_strobe: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> (woff >= 8'd6));
endmodule

bind nibreg_slave nibreg_slave_chk #(.POS_BASE(POS_BASE)) u_chk (.*);

// File: tb/tb_nibreg_slave.sv
module tb_nibreg_slave;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cmd_data = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [7:0]  rsp_data;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [23:0] trig_pos = 24'h123456;
    logic [23:0] stop_pos = 24'hABCDEF;
    logic        reg_we;
    logic [7:0]  reg_waddr;
    logic [7:0]  reg_wdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit stall  = 0;
    int cyc    = 0;

    logic [7:0] model [256];
    logic [7:0] m_addr = 8'h00;
    logic [3:0] m_dlo  = 4'h0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    nibreg_slave dut (.*);

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit in_win(input logic [7:0] a);
        return (a >= 8'hF0) && (a <= 8'hF5);
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        logic [47:0] w;
        w = {stop_pos, trig_pos};
        if (in_win(a)) return w[(a - 8'hF0)*8 +: 8];
        return model[a];
    endfunction

    // Monitor and scoreboard: compare each reply byte as it is taken.
    logic       held = 0;
    logic [7:0] held_data;
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (held) begin
                chk("R7 stalled reply kept", {rsp_valid, rsp_data}, {1'b1, held_data});
            end
            if (rsp_valid) chk("R7 input stalled", cmd_ready, 0);
            rsp_ready = stall ? (cyc % 3 == 0) : 1'b1;
            held = rsp_valid && !rsp_ready;
            held_data = rsp_data;
            if (rsp_valid && rsp_ready) begin
                if (exp_q.size() == 0) begin
                    chk("R8 unexpected reply", 1, 0);
                end else begin
                    chk(tag_q.pop_front(), rsp_data, exp_q.pop_front());
                end
            end
        end
    end

    // Drive one command byte, update the model, then check the write strobe.
    task automatic cmd(input logic [3:0] op, input logic [3:0] nib, input string tag);
        bit exp_we;
        logic [7:0] exp_wa, exp_wd;
        exp_we = 0;
        exp_wa = m_addr;
        exp_wd = {nib, m_dlo};
        case (op)
            4'h0: m_addr[3:0] = nib;
            4'h1: m_addr[7:4] = nib;
            4'h2: m_dlo = nib;
            4'h3: if (!in_win(m_addr)) begin
                exp_we = 1;
                model[m_addr] = exp_wd;
            end
            4'h4, 4'h5: begin
                exp_q.push_back(exp_read(m_addr));
                tag_q.push_back(tag);
                if (op == 4'h5) m_addr = m_addr + 8'd1;
            end
            default: ;
        endcase
        cmd_data  = {op, nib};
        cmd_valid = 1'b1;
        while (1) begin
            if (cmd_ready) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
        #1 cmd_valid = 1'b0;
        @(negedge clk);
        chk({tag, " strobe"}, reg_we, exp_we);
        if (exp_we) chk({tag, " strobe addr/data"}, {reg_waddr, reg_wdata}, {exp_wa, exp_wd});
    endtask

    task automatic set_addr(input logic [7:0] a, input string tag);
        cmd(4'h0, a[3:0], tag);
        cmd(4'h1, a[7:4], tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
        set_addr(a, tag);
        cmd(4'h2, d[3:0], tag);
        cmd(4'h3, d[7:4], tag);
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset cmd_ready", cmd_ready, 1);
        chk("R1 reset rsp_valid", rsp_valid, 0);
        chk("R1 reset reg_we", reg_we, 0);
        cmd(4'h4, 4'h0, "R1 reset address and contents");
        set_addr(8'h95, "R1");
        cmd(4'h4, 4'h0, "R1 storage cleared");

        // R3 / R5: basic write and non-incrementing read
        wr(8'h3C, 8'hA5, "R3");
        cmd(4'h4, 4'h0, "R5 read back");
        cmd(4'h4, 4'h0, "R5 address unchanged");

        // R2: only high nibble changes
        cmd(4'h1, 4'h4, "R2");
        cmd(4'h2, 4'h1, "R2");
        cmd(4'h3, 4'h9, "R2 write at 0x4C");
        cmd(4'h4, 4'h0, "R2 low nibble kept");

        // R4: lone commit reuses saved low nibble, bursts hit one address
        cmd(4'h3, 4'hE, "R4 lone commit");
        cmd(4'h4, 4'h0, "R4 lone commit result");
        cmd(4'h2, 4'h7, "R4");
        cmd(4'h3, 4'h2, "R4 burst pair 1");
        cmd(4'h2, 4'h5, "R4");
        cmd(4'h3, 4'h6, "R4 burst pair 2");
        cmd(4'h4, 4'h0, "R4 last pair wins");

        // R6 / R7: incrementing reads under a stalling receiver
        for (int i = 0; i < 4; i++) wr(8'h50 + 8'(i), 8'hC0 + 8'(i * 7), "R6");
        set_addr(8'h50, "R6");
        stall = 1;
        for (int i = 0; i < 4; i++) cmd(4'h5, 4'h0, "R6 incrementing read");
        cmd(4'h4, 4'h0, "R6 address advanced by four");
        stall = 0;

        // R6: wrap
        wr(8'hFF, 8'h77, "R6");
        wr(8'h00, 8'h11, "R6");
        set_addr(8'hFF, "R6");
        cmd(4'h5, 4'h0, "R6 read at 0xFF");
        cmd(4'h4, 4'h0, "R6 wrap to 0x00");

        // R8: unused opcodes
        wr(8'h22, 8'h5A, "R8");
        cmd(4'h6, 4'hF, "R8 opcode 6");
        cmd(4'h7, 4'h3, "R8 opcode 7");
        cmd(4'hF, 4'hF, "R8 opcode F");
        cmd(4'h8, 4'h1, "R8 opcode 8");
        cmd(4'h4, 4'h0, "R8 address kept");
        cmd(4'h3, 4'hB, "R8 data nibble kept");
        cmd(4'h4, 4'h0, "R8 data nibble kept readback");

        // R9: position window
        set_addr(8'hF0, "R9");
        stall = 1;
        for (int i = 0; i < 6; i++) cmd(4'h5, 4'h0, "R9 window byte order");
        stall = 0;
        wr(8'hF2, 8'h99, "R9 window write dropped");
        cmd(4'h4, 4'h0, "R9 window read after write");
        trig_pos = 24'h00FE00;
        set_addr(8'hF1, "R9");
        cmd(4'h4, 4'h0, "R9 live value");

        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R7 all replies delivered", exp_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule